// File: doc/BRIEF.md
# Receive FIFO with character timeout

This block sits between a serial receiver and the CPU's read port for received bytes. The receiver pushes each finished byte into a queue of up to 16 entries. The CPU pops bytes from the head of that queue. The block drives three levels towards an interrupt controller:

- **data ready**: at least one byte is held.
- **trigger reached**: the fill level is at or above a threshold that software selects.
- **timeout**: bytes have sat below that threshold with no read and no new stop bit for a set number of character times.

A sticky overrun flag records any byte that arrives while there is no room for it.

When the queue mode is switched off, the block acts as a single-byte holding register with an effective threshold of one. Any change of the mode bit empties the queue. The timeout counter advances on a character-time tick from the baud logic. It restarts on the centre of every received stop bit, on every read, and for as long as the queue is empty.

Top module: `rxq_top`

## Requirements
- R1: After reset, data_ready_o, trig_hit_o, timeout_o and overrun_o are all 0.
- R2: Bytes leave in arrival order. While data_ready_o is 1, rd_data_o shows the oldest byte. A pop_i cycle removes it, and in queue mode up to DEPTH (16) bytes are held.
- R3: data_ready_o is 1 exactly when at least one byte is held.
- R4: trig_sel_i selects the threshold as follows: 2'b00 gives 1 byte, 2'b01 gives DEPTH/4 (4), 2'b10 gives DEPTH/2 (8), and 2'b11 gives DEPTH-2 (14). trig_hit_o is 1 while the fill level is at or above the threshold, and returns to 0 as soon as the level drops below it.
- R5: A push when the level equals the capacity is dropped. Fullness is judged before any pop in the same cycle. A dropped push sets overrun_o, which stays 1 until a cycle with pop_i. If a drop and a pop_i happen in the same cycle, the flag stays set.
- R6: A pop_i while empty changes nothing, and later pushes are stored normally.
- R7: A counter advances on each char_tick_i. It is cleared in any cycle with stop_mid_i or pop_i, and while the queue is empty. timeout_o is 1 once the counter has reached TMO_CHARS (4) ticks, provided the level is non-zero and below the threshold.
- R8: timeout_o is never 1 while the queue is empty, nor while the level is at or above the threshold.
- R9: With fifo_en_i at 0, the capacity is one byte and the threshold is one, whatever trig_sel_i holds.
- R10: Any change of fifo_en_i empties the queue. A push in that same cycle is dropped without setting overrun_o.
- R11: A push and a pop in the same cycle, on a queue that is neither empty nor full, keep the level unchanged and preserve order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Received byte strobe |
| push_data_i | input | 8 | Received byte |
| stop_mid_i | input | 1 | Stop-bit centre strobe from the receiver |
| pop_i | input | 1 | CPU read strobe for the head byte |
| fifo_en_i | input | 1 | Queue mode enable |
| trig_sel_i | input | 2 | Threshold select code |
| char_tick_i | input | 1 | One pulse per character time |
| rd_data_o | output | 8 | Head byte |
| data_ready_o | output | 1 | At least one byte held |
| trig_hit_o | output | 1 | Level at or above threshold |
| timeout_o | output | 1 | Character timeout pending |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with DEPTH at 16 and TMO_CHARS at 4. At these values a full queue is 16 pushes away, so a seventeenth push reaches the overrun path in a handful of cycles. The same depth gives distinct thresholds of 1, 4, 8 and 14, so each select code can be checked on both the rising and the falling side. A four-tick timeout makes it cheap to approach the expiry boundary one tick at a time. It is equally cheap to show that a stop-bit strobe, a read, an empty queue or a level at the threshold each hold the timeout off.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] rxq_byte_t;

    typedef struct packed {
        logic      vld;
        rxq_byte_t data;
    } rxq_wr_t;

    typedef enum logic [1:0] {
        TRG_ONE  = 2'b00,
        TRG_QTR  = 2'b01,
        TRG_HALF = 2'b10,
        TRG_NEAR = 2'b11
    } rxq_trg_e;

    // Threshold in bytes for a select code at a given queue depth.
    function automatic int unsigned trig_bytes(rxq_trg_e sel, int unsigned depth);
        case (sel)
            TRG_ONE:  return 1;
            TRG_QTR:  return depth / 4;
            TRG_HALF: return depth / 2;
            default:  return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_i,
    input  logic [CW-1:0] cap_i,
    input  rxq_wr_t       wr_i,
    input  logic          rd_i,
    output rxq_byte_t     head_o,
    output logic [CW-1:0] fill_o,
    output logic          drop_o
);

    rxq_byte_t     mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
    logic [CW-1:0] fill_q;
    logic          full, do_wr, do_rd;

    always_comb begin
        full   = (fill_q >= cap_i);
        do_wr  = wr_i.vld && !full && !flush_i;
        do_rd  = rd_i && (fill_q != '0) && !flush_i;
        drop_o = wr_i.vld && full && !flush_i;
        wp_nx  = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
        rp_nx  = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wp_q   <= '0;
            rp_q   <= '0;
            fill_q <= '0;
        end else begin
            if (do_wr) wp_q <= wp_nx;
            if (do_rd) rp_q <= rp_nx;
            case ({do_wr, do_rd})
                2'b10:   fill_q <= fill_q + CW'(1);
                2'b01:   fill_q <= fill_q - CW'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_i.data;
    end

    assign head_o = mem[rp_q];
    assign fill_o = fill_q;

endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          en_i,
    input  logic [1:0]    sel_i,
    input  logic [CW-1:0] fill_i,
    output logic [CW-1:0] cap_o,
    output logic          hit_o,
    output logic          ready_o
);

    logic [CW-1:0] thr;

    always_comb begin
        if (en_i) begin
            cap_o = CW'(DEPTH);
            thr   = CW'(trig_bytes(rxq_trg_e'(sel_i), DEPTH));
        end else begin
            cap_o = CW'(1);
            thr   = CW'(1);
        end
        hit_o   = (fill_i >= thr);
        ready_o = (fill_i != '0);
    end

endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
    parameter int TMO_CHARS = 4,
    localparam int TW = $clog2(TMO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic empty_i,
    input  logic tick_i,
    input  logic below_i,
    output logic expired_o
);

    logic [TW-1:0] cnt_q;
    logic          at_lim;

    assign at_lim = (cnt_q == TW'(TMO_CHARS));

    always_ff @(posedge clk) begin
        if (rst || restart_i || empty_i)
            cnt_q <= '0;
        else if (tick_i && !at_lim)
            cnt_q <= cnt_q + TW'(1);
    end

    assign expired_o = at_lim && !empty_i && below_i;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_i,
    input  logic [7:0] push_data_i,
    input  logic       stop_mid_i,
    input  logic       pop_i,
    input  logic       fifo_en_i,
    input  logic [1:0] trig_sel_i,
    input  logic       char_tick_i,
    output logic [7:0] rd_data_o,
    output logic       data_ready_o,
    output logic       trig_hit_o,
    output logic       timeout_o,
    output logic       overrun_o
);

    localparam int CW = $clog2(DEPTH + 1);

    rxq_wr_t       wr_w;
    rxq_byte_t     head_w;
    logic [CW-1:0] fill_w, cap_w;
    logic          flush_w, drop_w, hit_w, ready_w, tmo_w;
    logic          en_q, ovr_q;

    assign wr_w    = '{vld: push_i, data: push_data_i};
    assign flush_w = (fifo_en_i != en_q);

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush_w),
        .cap_i   (cap_w),
        .wr_i    (wr_w),
        .rd_i    (pop_i),
        .head_o  (head_w),
        .fill_o  (fill_w),
        .drop_o  (drop_w)
    );

    rxq_level #(.DEPTH(DEPTH)) level_i (
        .en_i    (fifo_en_i),
        .sel_i   (trig_sel_i),
        .fill_i  (fill_w),
        .cap_o   (cap_w),
        .hit_o   (hit_w),
        .ready_o (ready_w)
    );

    rxq_tmo #(.TMO_CHARS(TMO_CHARS)) tmo_i (
        .clk       (clk),
        .rst       (rst),
        .restart_i (stop_mid_i | pop_i),
        .empty_i   (!ready_w),
        .tick_i    (char_tick_i),
        .below_i   (!hit_w),
        .expired_o (tmo_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            en_q <= fifo_en_i;
            if (drop_w)
                ovr_q <= 1'b1;
            else if (pop_i)
                ovr_q <= 1'b0;
        end
    end

    assign rd_data_o    = head_w;
    assign data_ready_o = ready_w;
    assign trig_hit_o   = hit_w;
    assign timeout_o    = tmo_w;
    assign overrun_o    = ovr_q;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          push_i,
    input logic          pop_i,
    input logic          stop_mid_i,
    input logic          data_ready_o,
    input logic          trig_hit_o,
    input logic          timeout_o,
    input logic          overrun_o,
    input logic [CW-1:0] fill_i,
    input logic [CW-1:0] cap_i,
    input logic          flush_i
);

    // R8
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !data_ready_o |-> !timeout_o);

    // R8
    tmo_below_trig_chk: assert property (@(posedge clk) disable iff (rst)
        trig_hit_o |-> !timeout_o);

    // R4
    hit_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        trig_hit_o |-> data_ready_o);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_i <= CW'(DEPTH));

    // R5
    drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && (fill_i == cap_i) && !flush_i) |=> overrun_o);

    // R5
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !pop_i) |=> overrun_o);

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mid_i || pop_i) |=> !timeout_o);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !data_ready_o);

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_ready_o && pop_i && !push_i) |=> !data_ready_o);

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .stop_mid_i   (stop_mid_i),
    .data_ready_o (data_ready_o),
    .trig_hit_o   (trig_hit_o),
    .timeout_o    (timeout_o),
    .overrun_o    (overrun_o),
    .fill_i       (fill_w),
    .cap_i        (cap_w),
    .flush_i      (flush_w)
);

// File: tb/rxq_top_tb.sv
module rxq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0, pop = 1'b0, stop = 1'b0, tick = 1'b0;
    logic [7:0] din = 8'h00;
    logic       en = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [7:0] dout;
    logic       dr, trig, tmo, ovr;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    rxq_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .push_i       (push),
        .push_data_i  (din),
        .stop_mid_i   (stop),
        .pop_i        (pop),
        .fifo_en_i    (en),
        .trig_sel_i   (sel),
        .char_tick_i  (tick),
        .rd_data_o    (dout),
        .data_ready_o (dr),
        .trig_hit_o   (trig),
        .timeout_o    (tmo),
        .overrun_o    (ovr)
    );

    // Vector: {push,pop,stop,tick, data, exp dr,trig,tmo,ovr, exp head}
    // Run with fifo mode on and threshold code 2'b01 (4 bytes).
    localparam int NV = 23;
    localparam logic [23:0] VEC [NV] = '{
        {4'b0000, 8'h00, 4'b0000, 8'h00},
        {4'b1000, 8'hA1, 4'b1000, 8'hA1},
        {4'b1000, 8'hB2, 4'b1000, 8'hA1},
        {4'b1000, 8'hC3, 4'b1000, 8'hA1},
        {4'b1000, 8'hD4, 4'b1100, 8'hA1},
        {4'b1000, 8'hE5, 4'b1100, 8'hA1},
        {4'b0100, 8'h00, 4'b1100, 8'hB2},
        {4'b0100, 8'h00, 4'b1000, 8'hC3},
        {4'b0001, 8'h00, 4'b1000, 8'hC3},
        {4'b0001, 8'h00, 4'b1000, 8'hC3},
        {4'b0011, 8'h00, 4'b1000, 8'hC3},
        {4'b0001, 8'h00, 4'b1000, 8'hC3},
        {4'b0001, 8'h00, 4'b1000, 8'hC3},
        {4'b0001, 8'h00, 4'b1000, 8'hC3},
        {4'b0001, 8'h00, 4'b1010, 8'hC3},
        {4'b0001, 8'h00, 4'b1010, 8'hC3},
        {4'b0100, 8'h00, 4'b1000, 8'hD4},
        {4'b0100, 8'h00, 4'b1000, 8'hE5},
        {4'b0100, 8'h00, 4'b0000, 8'h00},
        {4'b0001, 8'h00, 4'b0000, 8'h00},
        {4'b0001, 8'h00, 4'b0000, 8'h00},
        {4'b0001, 8'h00, 4'b0000, 8'h00},
        {4'b0001, 8'h00, 4'b0000, 8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle from a falling edge, return at the next falling edge.
    task automatic cyc(input logic p, input logic [7:0] d, input logic o,
                       input logic s, input logic t);
        push = p; din = d; pop = o; stop = s; tick = t;
        @(posedge clk);
        @(negedge clk);
        push = 1'b0; pop = 1'b0; stop = 1'b0; tick = 1'b0; din = 8'h00;
    endtask

    task automatic do_reset(input logic mode, input logic [1:0] code);
        rst = 1'b1;
        en  = mode;
        sel = code;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(0, 8'h00, 0, 0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);

        // R1 reset state
        do_reset(1'b0, 2'b00);
        chk("R1 dr", dr, 0);
        chk("R1 trig", trig, 0);
        chk("R1 tmo", tmo, 0);
        chk("R1 ovr", ovr, 0);

        // Vector table: R2 R3 R4 R7 R8
        do_reset(1'b1, 2'b01);
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][23], VEC[i][19:12], VEC[i][22], VEC[i][21], VEC[i][20]);
            chk("R3 dr vec", dr, VEC[i][11]);
            chk("R4 trig vec", trig, VEC[i][10]);
            chk("R7 tmo vec", tmo, VEC[i][9]);
            chk("R5 ovr vec", ovr, VEC[i][8]);
            if (VEC[i][11]) chk("R2 head vec", dout, VEC[i][7:0]);
        end

        // R1 reset while holding data
        cyc(1, 8'h77, 0, 0, 0);
        do_reset(1'b1, 2'b01);
        chk("R1 dr after reset", dr, 0);

        // R4 code 2'b11 rising edge, R2 full depth, R5 overrun
        do_reset(1'b1, 2'b11);
        for (int i = 0; i < 16; i++) begin
            cyc(1, 8'h10 + 8'(i), 0, 0, 0);
            chk("R4 trig fill14", trig, (i + 1 >= 14) ? 1 : 0);
            chk("R3 dr fill", dr, 1);
        end
        chk("R5 no ovr at full", ovr, 0);
        cyc(1, 8'hEE, 0, 0, 0);
        chk("R5 ovr set", ovr, 1);
        chk("R2 head kept", dout, 8'h10);
        cyc(1, 8'hFF, 1, 0, 0);
        chk("R5 set wins over clear", ovr, 1);
        chk("R5 full push dropped head", dout, 8'h11);
        chk("R4 trig at 15", trig, 1);
        for (int i = 1; i < 16; i++) begin
            chk("R2 order", dout, 8'h10 + 8'(i));
            cyc(0, 8'h00, 1, 0, 0);
            if (i == 1) chk("R5 ovr cleared by pop", ovr, 0);
        end
        chk("R3 drained", dr, 0);

        // R4 code 2'b10 both edges
        do_reset(1'b1, 2'b10);
        for (int i = 0; i < 8; i++) begin
            cyc(1, 8'h20 + 8'(i), 0, 0, 0);
            if (i == 6) chk("R4 trig at 7 of 8", trig, 0);
        end
        chk("R4 trig at 8", trig, 1);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R4 trig drops below 8", trig, 0);

        // R4 code 2'b00
        do_reset(1'b1, 2'b00);
        cyc(1, 8'h2A, 0, 0, 0);
        chk("R4 trig at 1", trig, 1);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R4 trig empty", trig, 0);

        // R6 pop while empty
        do_reset(1'b1, 2'b01);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R6 dr after empty pop", dr, 0);
        chk("R6 ovr after empty pop", ovr, 0);
        cyc(1, 8'h5A, 0, 0, 0);
        chk("R6 push after empty pop", dout, 8'h5A);
        chk("R6 dr one", dr, 1);

        // R11 simultaneous push and pop
        do_reset(1'b1, 2'b01);
        cyc(1, 8'h61, 0, 0, 0);
        cyc(1, 8'h62, 0, 0, 0);
        cyc(1, 8'h63, 1, 0, 0);
        chk("R11 head", dout, 8'h62);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R11 order", dout, 8'h63);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R11 level kept", dr, 0);

        // R9 disabled mode acts as one-byte register
        do_reset(1'b0, 2'b11);
        cyc(1, 8'h31, 0, 0, 0);
        chk("R9 dr", dr, 1);
        chk("R9 trig one", trig, 1);
        chk("R9 head", dout, 8'h31);
        cyc(1, 8'h32, 0, 0, 0);
        chk("R9 second byte overruns", ovr, 1);
        chk("R9 head unchanged", dout, 8'h31);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R9 empty after pop", dr, 0);
        chk("R5 ovr clear", ovr, 0);
        cyc(1, 8'h33, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 0, 1);
        chk("R8 no tmo at trigger disabled", tmo, 0);

        // R10 mode change flushes
        en = 1'b1;
        cyc(1, 8'h44, 0, 0, 0);
        chk("R10 flushed", dr, 0);
        chk("R10 no ovr", ovr, 0);
        cyc(1, 8'h45, 0, 0, 0);
        chk("R10 new push", dout, 8'h45);
        en = 1'b0;
        cyc(0, 8'h00, 0, 0, 0);
        chk("R10 flushed on disable", dr, 0);

        // R7 R8 timeout boundaries
        do_reset(1'b1, 2'b01);
        for (int i = 0; i < 4; i++) cyc(1, 8'h70 + 8'(i), 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 0, 0, 1);
        chk("R8 no tmo at trigger", tmo, 0);
        chk("R4 trig at 4", trig, 1);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R7 tmo after pop", tmo, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 0, 1);
        chk("R7 tmo after 3 ticks", tmo, 0);
        cyc(0, 8'h00, 0, 0, 1);
        chk("R7 tmo after 4 ticks", tmo, 1);
        cyc(0, 8'h00, 0, 1, 0);
        chk("R7 stop centre clears", tmo, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule